// File: doc/BRIEF.md
# Audio Clock Fault Monitor

This block watches the three clocks that feed an audio receiver: a master clock, a bit clock and a frame (left/right) clock. It runs on a free-running reference clock. In each frame period it counts master-clock cycles, bit-clock cycles and reference-clock cycles. Each count is handed into the reference domain through a toggle handshake. A change in either clock ratio, a change in the frame period, or frame edges that drift away from an internally generated frame sync is recorded as a fault.

Each fault sets a bit in an 8-bit status register. Three more bits are set by outside fault flags: PLL unlock, power-stage fault and over-temperature warning. Hardware never clears a bit. Software clears bits by writing zeros over them. A later read shows whether a fault keeps coming back. A separate `clk_err` output, independent of the sticky bits, stays high while any clock fault is still current, so a mute controller can act on it.

Top module: `aclk_fault_mon`

## Requirements
- R1: While reset is asserted and right after it is released, `status` reads 8'h00 and `clk_err` is 0.
- R2: A measurement is compared only once two consecutive identical measurements of that quantity have been seen. With steady clocks after reset, no status bit is ever set.
- R3: When the number of master-clock cycles per frame period changes, status bit 7 is set.
- R4: When the number of bit-clock cycles per frame period changes, status bit 5 is set.
- R5: When the frame period, counted in reference-clock cycles, differs from the previous period by more than FTOL (default 2) counts, status bit 4 is set. A difference of FTOL or less sets nothing.
- R6: An internal frame sync free-runs at the period captured when the frame measurement qualified. When a frame edge lands more than FTOL reference cycles away from the sync's wrap point, status bit 3 is set and the sync realigns to that edge. No slip is reported in a period that already raised bit 4.
- R7: A one-cycle high on `pll_unlock` sets bit 6, on `pwr_fault` sets bit 2, and on `ot_warn` sets bit 1. Bit 0 always reads 0.
- R8: Bits are sticky. A write with `reg_wr` high clears exactly those bits whose `reg_wdata` bit is 0, and writing 1 leaves a bit unchanged. A fault that sets a bit in the same cycle as a clearing write leaves it set.
- R9: After software clears a bit, it is set again if its fault persists. It stays 0 once the fault has gone.
- R10: `clk_err` rises when a clock fault is detected and stays high until that measurement qualifies again. For a slip it stays high until a frame passes without slip. It does not depend on the sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock; the status register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| mclk | input | 1 | Master clock being monitored |
| bclk | input | 1 | Bit clock being monitored |
| fclk | input | 1 | Frame (left/right) clock being monitored |
| pll_unlock | input | 1 | PLL lock-loss flag, reference domain |
| pwr_fault | input | 1 | Power-stage fault flag, reference domain |
| ot_warn | input | 1 | Over-temperature warning flag, reference domain |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 8 | Write data; a 0 bit clears that status bit |
| status | output | 8 | Sticky status: 7 master ratio, 6 PLL, 5 bit ratio, 4 frame rate, 3 slip, 2 power, 1 temperature, 0 zero |
| clk_err | output | 1 | Combined live clock-fault indication |

## Verification
On every cycle, the assertions check that status bits never fall without a clearing write, and that each transferred count arrives as a single-cycle strobe. They also check that a measurement qualifies only on a fresh count, that the internal sync phase stays inside its period, and that every rise of `clk_err` comes with a clock bit in the status. Only the bench scenarios can show that a particular clock change reaches the right bit and leaves the others alone. The same holds for a drift within FTOL that slips phase but raises no rate error, and for a cleared bit that returns only while its fault persists.

// File: rtl/aclk_fault_pkg.sv
package aclk_fault_pkg;
  localparam int ST_W     = 8;
  localparam int B_MRATIO = 7;
  localparam int B_PLL    = 6;
  localparam int B_BRATIO = 5;
  localparam int B_FRATE  = 4;
  localparam int B_SLIP   = 3;
  localparam int B_PWR    = 2;
  localparam int B_OTW    = 1;
  localparam int NCH      = 3;
  localparam int CH_M     = 0;
  localparam int CH_B     = 1;
  localparam int CH_F     = 2;
  typedef logic [ST_W-1:0] stat_t;
endpackage

// File: rtl/aclk_rst_sync.sv
module aclk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= 2'b00;
    else         pipe_q <= {pipe_q[0], 1'b1};
  end

  assign srst_n = pipe_q[1];
endmodule

// File: rtl/aclk_period_count.sv
// Counts source-clock cycles between frame-clock rising edges in the
// source domain; publishes each finished count with a toggle.
module aclk_period_count #(
  parameter int W = 16
) (
  input  logic         sclk,
  input  logic         arst_n,
  input  logic         fclk,
  output logic [W-1:0] hold,
  output logic         tog
);
  logic         srst_n;
  logic [2:0]   fs_q;
  logic [W-1:0] cnt_q, cnt_d, hold_q, hold_d;
  logic         tog_q, tog_d;
  logic         rise;

  aclk_rst_sync u_rs (.clk(sclk), .arst_n(arst_n), .srst_n(srst_n));

  assign rise = fs_q[1] & ~fs_q[2];

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    tog_d  = tog_q;
    if (rise) begin
      hold_d = cnt_q;
      cnt_d  = W'(1);
      tog_d  = ~tog_q;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      fs_q   <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      fs_q   <= {fs_q[1:0], fclk};
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      tog_q  <= tog_d;
    end
  end

  assign hold = hold_q;
  assign tog  = tog_q;
endmodule

// File: rtl/aclk_xfer.sv
// Toggle-handshake receiver: captures the held count when the toggle flips.
module aclk_xfer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tog_in,
  input  logic [W-1:0] data_in,
  output logic         valid,
  output logic [W-1:0] data
);
  logic [2:0]   ts_q;
  logic         chg;
  logic         valid_q;
  logic [W-1:0] data_q, data_d;

  assign chg = ts_q[2] ^ ts_q[1];

  always_comb begin
    data_d = data_q;
    if (chg) data_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      ts_q    <= {ts_q[1:0], tog_in};
      valid_q <= chg;
      data_q  <= data_d;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  // R3/R4: each transferred count appears as a single-cycle strobe
  a_r3_xfer_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/aclk_qual.sv
// Qualifies a stream of measurements and flags changes beyond TOL.
module aclk_qual #(
  parameter int W   = 16,
  parameter int TOL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [W-1:0] meas,
  output logic         err,
  output logic         armed,
  output logic         fault
);
  localparam logic [W-1:0] TOLV = W'(TOL);

  logic [W-1:0] prev_q, prev_d, diff;
  logic         have_q, have_d, armed_q, armed_d, fault_q, fault_d;

  assign diff = (meas > prev_q) ? (meas - prev_q) : (prev_q - meas);
  assign err  = valid && armed_q && (diff > TOLV);

  always_comb begin
    prev_d  = prev_q;
    have_d  = have_q;
    armed_d = armed_q;
    fault_d = fault_q;
    if (valid) begin
      prev_d = meas;
      have_d = 1'b1;
      if (err) begin
        armed_d = 1'b0;
        fault_d = 1'b1;
      end else if (!armed_q && have_q && (meas == prev_q)) begin
        armed_d = 1'b1;
        fault_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      armed_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      have_q  <= have_d;
      armed_q <= armed_d;
      fault_q <= fault_d;
    end
  end

  assign armed = armed_q;
  assign fault = fault_q;

  // R2: qualification only happens on a freshly delivered measurement
  a_r2_arm_on_meas: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(valid));
  // R10: a live fault ends only by requalifying
  a_r10_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> armed_q);
endmodule

// File: rtl/aclk_slip.sv
// Free-running internal frame sync; reports frame edges landing off its wrap.
module aclk_slip #(
  parameter int W   = 16,
  parameter int TOL = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [W-1:0] meas,
  input  logic         armed,
  input  logic         rate_err,
  output logic         slip,
  output logic         fault
);
  localparam logic [W-1:0] TOLV = W'(TOL);

  logic [W-1:0] isync_q, isync_d, lock_q, lock_d, dev, inc;
  logic         arm_d1_q, locked, fault_q, fault_d;

  assign locked = armed && arm_d1_q;
  assign inc    = isync_q + W'(1);
  assign dev    = (isync_q <= (lock_q >> 1)) ? isync_q : (lock_q - isync_q);
  assign slip   = valid && locked && !rate_err && (dev > TOLV);

  always_comb begin
    lock_d  = lock_q;
    isync_d = isync_q;
    fault_d = fault_q;
    if (armed && !arm_d1_q) lock_d = meas;
    if (valid && (!locked || slip)) begin
      isync_d = W'(1);
    end else if (locked) begin
      isync_d = (inc >= lock_q) ? '0 : inc;
    end else if (isync_q != '1) begin
      isync_d = inc;
    end
    if (valid) fault_d = slip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isync_q  <= '0;
      lock_q   <= '0;
      arm_d1_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      isync_q  <= isync_d;
      lock_q   <= lock_d;
      arm_d1_q <= armed;
      fault_q  <= fault_d;
    end
  end

  assign fault = fault_q;

  // R6: once locked, the internal sync phase stays inside its period
  a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> (isync_q < lock_q));
endmodule

// File: rtl/aclk_fault_mon.sv
module aclk_fault_mon
  import aclk_fault_pkg::*;
#(
  parameter int CW   = 16,
  parameter int FTOL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk,
  input  logic       bclk,
  input  logic       fclk,
  input  logic       pll_unlock,
  input  logic       pwr_fault,
  input  logic       ot_warn,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] status,
  output logic       clk_err
);
  logic           rst_n_s;
  logic [NCH-1:0] sclk, tog, vld, err, armed, fault;
  logic [CW-1:0]  hold [NCH];
  logic [CW-1:0]  meas [NCH];
  logic           slip, slip_fault;
  stat_t          st_q, st_d, set_v;

  aclk_rst_sync u_rs (.clk(clk), .arst_n(rst_n), .srst_n(rst_n_s));

  assign sclk[CH_M] = mclk;
  assign sclk[CH_B] = bclk;
  assign sclk[CH_F] = clk;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    aclk_period_count #(.W(CW)) u_cnt (
      .sclk(sclk[i]), .arst_n(rst_n), .fclk(fclk),
      .hold(hold[i]), .tog(tog[i]));
    aclk_xfer #(.W(CW)) u_xfer (
      .clk(clk), .rst_n(rst_n_s), .tog_in(tog[i]), .data_in(hold[i]),
      .valid(vld[i]), .data(meas[i]));
    aclk_qual #(.W(CW), .TOL((i == CH_F) ? FTOL : 0)) u_qual (
      .clk(clk), .rst_n(rst_n_s), .valid(vld[i]), .meas(meas[i]),
      .err(err[i]), .armed(armed[i]), .fault(fault[i]));
  end

  aclk_slip #(.W(CW), .TOL(FTOL)) u_slip (
    .clk(clk), .rst_n(rst_n_s), .valid(vld[CH_F]), .meas(meas[CH_F]),
    .armed(armed[CH_F]), .rate_err(err[CH_F]), .slip(slip),
    .fault(slip_fault));

  always_comb begin
    set_v           = '0;
    set_v[B_MRATIO] = err[CH_M];
    set_v[B_PLL]    = pll_unlock;
    set_v[B_BRATIO] = err[CH_B];
    set_v[B_FRATE]  = err[CH_F];
    set_v[B_SLIP]   = slip;
    set_v[B_PWR]    = pwr_fault;
    set_v[B_OTW]    = ot_warn;
    st_d = reg_wr ? (st_q & reg_wdata) : st_q;
    st_d = st_d | set_v;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= '0;
    else          st_q <= st_d;
  end

  assign status  = st_q;
  assign clk_err = |fault | slip_fault;

  // R8: without a write, no status bit ever falls
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    !reg_wr |=> ((st_q & $past(st_q)) == $past(st_q)));
  // R10: each rise of the live error marks a clock bit in the status
  a_r10_err_marks: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(clk_err) |-> (st_q[B_MRATIO] | st_q[B_BRATIO] | st_q[B_FRATE] | st_q[B_SLIP]));
  // R7: bit 0 carries no fault
  a_r7_bit0: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> !st_q[0]);
endmodule

// File: tb/tb_aclk_fault_mon.sv
`timescale 1ns/1ps
module tb_aclk_fault_mon;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mclk, bclk, fclk;
  logic       pll_unlock, pwr_fault, ot_warn, reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] status;
  logic       clk_err;

  int  n_chk = 0, n_fail = 0, cerr_cnt = 0;
  bit  done = 1'b0;

  real half_m = 10.0, p_half;
  int  mpf = 64, bdiv = 4, p_mpf, p_bdiv, k = 0;
  bit  pend = 1'b0;

  aclk_fault_mon dut (
    .clk(clk), .rst_n(rst_n), .mclk(mclk), .bclk(bclk), .fclk(fclk),
    .pll_unlock(pll_unlock), .pwr_fault(pwr_fault), .ot_warn(ot_warn),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .status(status),
    .clk_err(clk_err));

  always #2.5 clk = ~clk;

  initial begin
    mclk = 0; fclk = 0; bclk = 0;
    #1;
    forever begin
      #(half_m) mclk = 1;
      #(half_m) mclk = 0;
      k = (k + 1) % mpf;
      if (k == 0 && pend) begin
        half_m = p_half; mpf = p_mpf; bdiv = p_bdiv; pend = 0;
      end
      fclk = (k < mpf / 2);
      bclk = ((k % bdiv) >= bdiv / 2);
    end
  end

  always @(negedge clk) if (clk_err) cerr_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic set_clocks(input real h, input int m, input int b);
    p_half = h; p_mpf = m; p_bdiv = b; pend = 1;
  endtask

  task automatic frames(input int n);
    repeat (n) @(posedge fclk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 8'hFF;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(status == 8'h00, "R1 status in reset", status, 0);
    chk(clk_err == 1'b0, "R1 clk_err in reset", clk_err, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    chk(status == 8'h00, "R1 status after release", status, 0);
  endtask

  task automatic t_startup;
    frames(10);
    chk(status == 8'h00, "R2 steady start no faults", status, 0);
    chk(cerr_cnt == 0, "R2 no clk_err at start", cerr_cnt, 0);
  endtask

  task automatic t_mratio;
    cerr_cnt = 0;
    set_clocks(5.0, 128, 8);
    frames(8);
    chk(status[7] == 1'b1, "R3 master ratio bit", status, 8'h80);
    chk(status[5:3] == 3'b000, "R5 no rate/bit/slip on ratio change", status, 8'h80);
    chk(cerr_cnt > 0, "R10 clk_err raised", cerr_cnt, 1);
    chk(clk_err == 1'b0, "R10 clk_err clears after requalify", clk_err, 0);
    chk(status[7] == 1'b1, "R10 sticky independent of clk_err", status, 8'h80);
    wr(8'h00);
    chk(status == 8'h00, "R8 write zero clears", status, 0);
  endtask

  task automatic t_bratio;
    set_clocks(5.0, 128, 4);
    frames(8);
    chk(status == 8'h20, "R4 bit ratio only bit 5", status, 8'h20);
    wr(8'h00);
  endtask

  task automatic t_frate;
    set_clocks(6.25, 128, 4);
    frames(8);
    chk(status == 8'h10, "R5 frame rate only bit 4", status, 8'h10);
    wr(8'hFF);
    chk(status == 8'h10, "R8 writing ones keeps bit", status, 8'h10);
    wr(8'hEF);
    chk(status == 8'h00, "R8 zero at bit 4 clears it", status, 0);
  endtask

  task automatic t_slip;
    set_clocks(6.28, 128, 4);
    frames(8);
    chk(status[3] == 1'b1, "R6 drift raises slip", status, 8'h08);
    chk(status[4] == 1'b0, "R5 drift within tolerance no rate error", status, 8'h08);
    wr(8'h00);
    frames(6);
    chk(status[3] == 1'b1, "R9 persistent slip sets again", status, 8'h08);
    set_clocks(6.25, 128, 4);
    frames(6);
    wr(8'h00);
    frames(6);
    chk(status == 8'h00, "R9 gone fault stays clear", status, 0);
    chk(clk_err == 1'b0, "R10 clk_err low when stable", clk_err, 0);
  endtask

  task automatic t_flags;
    @(negedge clk); pll_unlock = 1; @(negedge clk); pll_unlock = 0; @(negedge clk);
    chk(status == 8'h40, "R7 pll flag bit 6", status, 8'h40);
    @(negedge clk); pwr_fault = 1; @(negedge clk); pwr_fault = 0; @(negedge clk);
    chk(status == 8'h44, "R7 power flag bit 2", status, 8'h44);
    @(negedge clk); ot_warn = 1; @(negedge clk); ot_warn = 0; @(negedge clk);
    chk(status == 8'h46, "R7 temperature flag bit 1", status, 8'h46);
    chk(status[0] == 1'b0, "R7 bit 0 zero", status, 0);
    @(negedge clk); ot_warn = 1; reg_wr = 1; reg_wdata = 8'h00;
    @(negedge clk); ot_warn = 0; reg_wr = 0; reg_wdata = 8'hFF;
    @(negedge clk);
    chk(status == 8'h02, "R8 set wins over clearing write", status, 8'h02);
  endtask

  initial begin
    rst_n = 0; pll_unlock = 0; pwr_fault = 0; ot_warn = 0;
    reg_wr = 0; reg_wdata = 8'hFF;
    repeat (5) @(negedge clk);
    t_reset;
    t_startup;
    t_mratio;
    t_bratio;
    t_frate;
    t_slip;
    t_flags;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule